// File: doc/BRIEF.md
# Accumulator and Multiplier-Quotient Arithmetic Unit

This block is the arithmetic datapath of a small word-serial processor. It keeps two word registers: an accumulator (AC) and a multiplier-quotient register (MQ). A sequencer presents an 8-bit operation code and a word fetched from memory, then raises `start` for one cycle. The unit then loads, negates, takes the absolute value of, adds, subtracts or shifts into AC, moves words between MQ, AC and the operand, or runs a long multiply or divide. After that it pulses `done`.

Multiply and divide work on signed magnitudes, one bit per clock. The sign is fixed up when the loop finishes. A multiply leaves the double-length product split across AC (upper word) and MQ (lower word). A divide leaves the quotient in MQ and the remainder in AC. A zero divisor is refused at once and raises an error flag. The sign of AC is brought out on its own pin so that the sequencer can make conditional branch decisions without reading the full word.

Top module: `acmq_unit`

## Requirements
- R1: While `rst_n` is low, and straight after it is released, AC and MQ read zero and `busy`, `done` and `div_by_zero` are low.
- R2: Words are two's complement, and bit WORD_W-1 is the sign. `ac_neg` always equals the sign bit of `ac_out`.
- R3: Opcode 8'h01 loads the operand into AC, 8'h02 loads its negation, 8'h03 loads its absolute value and 8'h04 loads the negation of its absolute value. MQ is unchanged.
- R4: Opcode 8'h0A copies MQ into AC. Opcode 8'h09 loads the operand into MQ and leaves AC unchanged.
- R5: AC is replaced by AC plus operand for opcode 8'h05, AC plus the operand's absolute value for 8'h07, AC minus operand for 8'h06, and AC minus the operand's absolute value for 8'h08. All sums wrap modulo 2^WORD_W.
- R6: Opcode 8'h14 shifts AC left one place and fills the low bit with zero. Opcode 8'h15 shifts AC right one place and copies the sign bit into the top bit.
- R7: Every operation other than a running multiply or divide is accepted at the edge that samples `start` with `busy` low. Its result and a one-cycle `done` are visible right after that edge, and `busy` never rises.
- R8: Opcode 8'h0B forms the signed 2·WORD_W-bit product of operand and MQ. The upper word goes to AC and the lower word to MQ.
- R9: Opcode 8'h0C divides AC by the operand. The quotient is truncated toward zero and goes to MQ. The remainder takes the sign of the dividend and goes to AC.
- R10: For multiply and for divide with a nonzero divisor, `busy` is high after the accepting edge. AC, MQ and `done` change at the WORD_W+1-th edge after the accepting edge, and `busy` falls at that same edge.
- R11: Opcode 8'h0C with a zero operand completes like a single-cycle operation. `div_by_zero` is high together with `done`, and AC and MQ keep their values.
- R12: A `start` that arrives while `busy` is high is ignored. It causes no extra `done` and does not alter the running result.
- R13: Any opcode not listed above completes in one cycle with `done` and changes neither AC nor MQ.
- R14: AC and MQ change only at an edge after which `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to execute `opcode` |
| opcode | input | 8 | Operation code |
| operand | input | WORD_W | Memory operand word |
| busy | output | 1 | Multiply or divide in progress |
| done | output | 1 | One-cycle completion pulse |
| div_by_zero | output | 1 | Divide refused because the operand is zero (with `done`) |
| ac_out | output | WORD_W | Accumulator contents |
| mq_out | output | WORD_W | Multiplier-quotient register contents |
| ac_neg | output | 1 | Sign bit of the accumulator |

## Verification
Two situations are hard to reach from the pins. The first is a `start` that lands in the middle of a long operation. The stimulus sets it up on purpose by raising a load request a few cycles into a multiply. It then checks that the product still lands unchanged, that only one `done` appears, and that AC holds still both during and after the run. The second is the set of operand extremes where sign handling breaks down: the most negative word, the largest positive word squared, a shift that carries into the sign bit, and a divide with mixed signs. These are written as table entries whose expected words are worked out by hand from the requirements.

// File: rtl/acmq_pkg.sv
package acmq_pkg;

   localparam int OP_W = 8;

   typedef enum logic [OP_W-1:0] {
      OP_LD      = 8'h01,
      OP_LD_NEG  = 8'h02,
      OP_LD_ABS  = 8'h03,
      OP_LD_NABS = 8'h04,
      OP_ADD     = 8'h05,
      OP_SUB     = 8'h06,
      OP_ADD_ABS = 8'h07,
      OP_SUB_ABS = 8'h08,
      OP_MQ_LD   = 8'h09,
      OP_MQ_TO_A = 8'h0A,
      OP_MUL     = 8'h0B,
      OP_DIV     = 8'h0C,
      OP_SHL     = 8'h14,
      OP_SHR     = 8'h15
   } acmq_op_e;

endpackage

// File: rtl/acmq_mag.sv
module acmq_mag #(
   parameter int WORD_W = 40
) (
   input  logic [WORD_W-1:0] val_i,
   output logic [WORD_W-1:0] mag_o
);

   // unsigned magnitude; the most negative word maps to 2^(WORD_W-1)
   always_comb begin
      mag_o = val_i[WORD_W-1] ? (~val_i + 1'b1) : val_i;
   end

endmodule

// File: rtl/acmq_mul.sv
module acmq_mul #(
   parameter int WORD_W = 40
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  go_i,
   input  logic [WORD_W-1:0]     mcand_i,
   input  logic [WORD_W-1:0]     mplier_i,
   output logic                  fin_o,
   output logic [2*WORD_W-1:0]   prod_o
);

   localparam int CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   logic [WORD_W-1:0] mcand_q;
   logic [WORD_W-1:0] hi_q;
   logic [WORD_W-1:0] lo_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              run_q;
   logic [WORD_W:0]   sum;

   always_comb begin
      sum = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mcand_q} : '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand_q <= '0;
         hi_q    <= '0;
         lo_q    <= '0;
         cnt_q   <= '0;
         run_q   <= 1'b0;
         fin_o   <= 1'b0;
      end else begin
         fin_o <= 1'b0;
         if (go_i) begin
            mcand_q <= mcand_i;
            hi_q    <= '0;
            lo_q    <= mplier_i;
            cnt_q   <= '0;
            run_q   <= 1'b1;
         end else if (run_q) begin
            hi_q  <= sum[WORD_W:1];
            lo_q  <= {sum[0], lo_q[WORD_W-1:1]};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
               run_q <= 1'b0;
               fin_o <= 1'b1;
            end
         end
      end
   end

   assign prod_o = {hi_q, lo_q};

endmodule

// File: rtl/acmq_div.sv
module acmq_div #(
   parameter int WORD_W = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic [WORD_W-1:0] dvd_i,
   input  logic [WORD_W-1:0] dvs_i,
   output logic              fin_o,
   output logic [WORD_W-1:0] quo_o,
   output logic [WORD_W-1:0] rem_o
);

   localparam int CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   logic [WORD_W-1:0] dvs_q;
   logic [WORD_W-1:0] rem_q;
   logic [WORD_W-1:0] quo_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              run_q;
   logic [WORD_W:0]   shifted;
   logic              fits;
   logic [WORD_W-1:0] diff;

   // restoring step: bring down one dividend bit, subtract when it fits
   always_comb begin
      shifted = {rem_q, quo_q[WORD_W-1]};
      fits    = shifted >= {1'b0, dvs_q};
      diff    = shifted[WORD_W-1:0] - dvs_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dvs_q <= '0;
         rem_q <= '0;
         quo_q <= '0;
         cnt_q <= '0;
         run_q <= 1'b0;
         fin_o <= 1'b0;
      end else begin
         fin_o <= 1'b0;
         if (go_i) begin
            dvs_q <= dvs_i;
            rem_q <= '0;
            quo_q <= dvd_i;
            cnt_q <= '0;
            run_q <= 1'b1;
         end else if (run_q) begin
            rem_q <= fits ? diff : shifted[WORD_W-1:0];
            quo_q <= {quo_q[WORD_W-2:0], fits};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
               run_q <= 1'b0;
               fin_o <= 1'b1;
            end
         end
      end
   end

   assign quo_o = quo_q;
   assign rem_o = rem_q;

endmodule

// File: rtl/acmq_unit.sv
module acmq_unit
   import acmq_pkg::*;
#(
   parameter int WORD_W    = 40,
   parameter bit SHR_ARITH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [OP_W-1:0]   opcode,
   input  logic [WORD_W-1:0] operand,
   output logic              busy,
   output logic              done,
   output logic              div_by_zero,
   output logic [WORD_W-1:0] ac_out,
   output logic [WORD_W-1:0] mq_out,
   output logic              ac_neg
);

   localparam int PROD_W = 2 * WORD_W;

   generate
      if (WORD_W < 4) begin : g_chk_width
         $error("acmq_unit: WORD_W must be at least 4");
      end
   endgenerate

   logic [WORD_W-1:0] ac_q, mq_q;
   logic              busy_q, done_q, dz_q;
   logic              kind_div_q;
   logic              neg_main_q, neg_rem_q;

   logic [WORD_W-1:0] op_mag, ac_mag, mq_mag;
   logic [WORD_W-1:0] op_neg, op_nabs;
   logic [WORD_W-1:0] ac_shr;
   logic              accept, go_mul, go_div, op_zero;
   logic              mul_fin, div_fin, eng_fin;
   logic [PROD_W-1:0] mul_prod, prod_s;
   logic [WORD_W-1:0] quo_raw, rem_raw, quo_s, rem_s;

   acmq_mag #(.WORD_W(WORD_W)) u_mag_op (.val_i(operand), .mag_o(op_mag));
   acmq_mag #(.WORD_W(WORD_W)) u_mag_ac (.val_i(ac_q),    .mag_o(ac_mag));
   acmq_mag #(.WORD_W(WORD_W)) u_mag_mq (.val_i(mq_q),    .mag_o(mq_mag));

   always_comb begin
      op_neg  = ~operand + 1'b1;
      op_nabs = ~op_mag + 1'b1;
      op_zero = (operand == '0);
      accept  = start && !busy_q;
      go_mul  = accept && (opcode == OP_MUL);
      go_div  = accept && (opcode == OP_DIV) && !op_zero;
   end

   generate
      if (SHR_ARITH) begin : g_shr_arith
         assign ac_shr = {ac_q[WORD_W-1], ac_q[WORD_W-1:1]};
      end else begin : g_shr_logic
         assign ac_shr = {1'b0, ac_q[WORD_W-1:1]};
      end
   endgenerate

   acmq_mul #(.WORD_W(WORD_W)) u_mul (
      .clk      (clk),
      .rst_n    (rst_n),
      .go_i     (go_mul),
      .mcand_i  (op_mag),
      .mplier_i (mq_mag),
      .fin_o    (mul_fin),
      .prod_o   (mul_prod)
   );

   acmq_div #(.WORD_W(WORD_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .go_i  (go_div),
      .dvd_i (ac_mag),
      .dvs_i (op_mag),
      .fin_o (div_fin),
      .quo_o (quo_raw),
      .rem_o (rem_raw)
   );

   // sign fix-up applied once, on the engine's final magnitudes
   always_comb begin
      prod_s  = neg_main_q ? (~mul_prod + 1'b1) : mul_prod;
      quo_s   = neg_main_q ? (~quo_raw + 1'b1) : quo_raw;
      rem_s   = neg_rem_q  ? (~rem_raw + 1'b1) : rem_raw;
      eng_fin = kind_div_q ? div_fin : mul_fin;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ac_q       <= '0;
         mq_q       <= '0;
         busy_q     <= 1'b0;
         done_q     <= 1'b0;
         dz_q       <= 1'b0;
         kind_div_q <= 1'b0;
         neg_main_q <= 1'b0;
         neg_rem_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         dz_q   <= 1'b0;
         if (busy_q) begin
            if (eng_fin) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               if (kind_div_q) begin
                  ac_q <= rem_s;
                  mq_q <= quo_s;
               end else begin
                  ac_q <= prod_s[PROD_W-1:WORD_W];
                  mq_q <= prod_s[WORD_W-1:0];
               end
            end
         end else if (start) begin
            done_q <= 1'b1;
            case (opcode)
               OP_LD:      ac_q <= operand;
               OP_LD_NEG:  ac_q <= op_neg;
               OP_LD_ABS:  ac_q <= op_mag;
               OP_LD_NABS: ac_q <= op_nabs;
               OP_ADD:     ac_q <= ac_q + operand;
               OP_ADD_ABS: ac_q <= ac_q + op_mag;
               OP_SUB:     ac_q <= ac_q - operand;
               OP_SUB_ABS: ac_q <= ac_q - op_mag;
               OP_MQ_LD:   mq_q <= operand;
               OP_MQ_TO_A: ac_q <= mq_q;
               OP_SHL:     ac_q <= {ac_q[WORD_W-2:0], 1'b0};
               OP_SHR:     ac_q <= ac_shr;
               OP_MUL: begin
                  done_q     <= 1'b0;
                  busy_q     <= 1'b1;
                  kind_div_q <= 1'b0;
                  neg_main_q <= operand[WORD_W-1] ^ mq_q[WORD_W-1];
               end
               OP_DIV: begin
                  if (op_zero) begin
                     dz_q <= 1'b1;
                  end else begin
                     done_q     <= 1'b0;
                     busy_q     <= 1'b1;
                     kind_div_q <= 1'b1;
                     neg_main_q <= operand[WORD_W-1] ^ ac_q[WORD_W-1];
                     neg_rem_q  <= ac_q[WORD_W-1];
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign busy        = busy_q;
   assign done        = done_q;
   assign div_by_zero = dz_q;
   assign ac_out      = ac_q;
   assign mq_out      = mq_q;
   assign ac_neg      = ac_q[WORD_W-1];

endmodule

// File: rtl/acmq_unit_chk.sv
module acmq_unit_chk
   import acmq_pkg::*;
#(
   parameter int WORD_W = 40
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [OP_W-1:0]   opcode,
   input logic              busy,
   input logic              done,
   input logic              div_by_zero,
   input logic [WORD_W-1:0] ac_out,
   input logic [WORD_W-1:0] mq_out
);

   p_single_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && opcode != OP_MUL && opcode != OP_DIV) |=> (done && !busy));

   p_long_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && opcode == OP_MUL) |=> (busy && !done));

   p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_dz_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      div_by_zero |-> (done && $stable(ac_out) && $stable(mq_out)));

   p_busy_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   p_busy_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (busy || done));

   p_ac_write_r14: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ac_out) |-> done);

   p_mq_write_r14: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mq_out) |-> done);

endmodule

bind acmq_unit acmq_unit_chk #(.WORD_W(WORD_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .opcode      (opcode),
   .busy        (busy),
   .done        (done),
   .div_by_zero (div_by_zero),
   .ac_out      (ac_out),
   .mq_out      (mq_out)
);

// File: tb/acmq_unit_tb_top.sv
module acmq_unit_tb_top;

   localparam int CLK_P = 10;
   localparam int W     = 40;
   localparam int NV    = 32;

   typedef struct packed {
      logic [7:0]   op;
      logic [W-1:0] opnd;
      logic [W-1:0] ac;
      logic [W-1:0] mq;
   } vec_t;

   // each row: opcode, operand, AC after, MQ after (rows run in sequence)
   localparam vec_t TBL [NV] = '{
      '{8'h01, 40'sd7,          40'sd7,          40'sd0},          // R3
      '{8'h02, 40'sd7,          -40'sd7,         40'sd0},          // R3
      '{8'h03, -40'sd9,         40'sd9,          40'sd0},          // R3
      '{8'h04, 40'sd9,          -40'sd9,         40'sd0},          // R3
      '{8'h04, -40'sd4,         -40'sd4,         40'sd0},          // R3
      '{8'h05, 40'sd10,         40'sd6,          40'sd0},          // R5
      '{8'h07, -40'sd3,         40'sd9,          40'sd0},          // R5
      '{8'h06, -40'sd1,         40'sd10,         40'sd0},          // R5
      '{8'h08, -40'sd15,        -40'sd5,         40'sd0},          // R5
      '{8'h14, 40'sd0,          -40'sd10,        40'sd0},          // R6
      '{8'h15, 40'sd0,          -40'sd5,         40'sd0},          // R6
      '{8'h15, 40'sd0,          -40'sd3,         40'sd0},          // R6
      '{8'h09, 40'sd6,          -40'sd3,         40'sd6},          // R4
      '{8'h0B, -40'sd7,         -40'sd1,         -40'sd42},        // R8
      '{8'h01, 40'sd100,        40'sd100,        -40'sd42},        // R3
      '{8'h0C, -40'sd7,         40'sd2,          -40'sd14},        // R9
      '{8'h01, -40'sd100,       -40'sd100,       -40'sd14},        // R3
      '{8'h0C, 40'sd7,          -40'sd2,         -40'sd14},        // R9
      '{8'h0A, 40'sd0,          -40'sd14,        -40'sd14},        // R4
      '{8'hFF, 40'sd123,        -40'sd14,        -40'sd14},        // R13
      '{8'h01, 40'h4000000001,  40'h4000000001,  -40'sd14},        // R3
      '{8'h14, 40'sd0,          40'h8000000002,  -40'sd14},        // R6
      '{8'h15, 40'sd0,          40'hC000000001,  -40'sd14},        // R6
      '{8'h09, 40'h7FFFFFFFFF,  40'hC000000001,  40'h7FFFFFFFFF},  // R4
      '{8'h0B, 40'h7FFFFFFFFF,  40'h3FFFFFFFFF,  40'h0000000001},  // R8
      '{8'h09, 40'h8000000000,  40'h3FFFFFFFFF,  40'h8000000000},  // R4
      '{8'h0B, -40'sd1,         40'h0000000000,  40'h8000000000},  // R8
      '{8'h01, 40'h7FFFFFFFFF,  40'h7FFFFFFFFF,  40'h8000000000},  // R3
      '{8'h0C, 40'sd3,          40'h0000000001,  40'h2AAAAAAAAA},  // R9
      '{8'h01, -40'sd7,         -40'sd7,         40'h2AAAAAAAAA},  // R3
      '{8'h0C, -40'sd2,         -40'sd1,         40'sd3},          // R9
      '{8'h00, 40'sd5,          -40'sd1,         40'sd3}           // R13
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [7:0]   opcode = '0;
   logic [W-1:0] operand = '0;
   logic         busy, done, div_by_zero, ac_neg;
   logic [W-1:0] ac_out, mq_out;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  finished = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   acmq_unit #(.WORD_W(W)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .opcode      (opcode),
      .operand     (operand),
      .busy        (busy),
      .done        (done),
      .div_by_zero (div_by_zero),
      .ac_out      (ac_out),
      .mq_out      (mq_out),
      .ac_neg      (ac_neg)
   );

   task automatic check(input string req, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [7:0] op);
      case (op)
         8'h01, 8'h02, 8'h03, 8'h04: return "R3";
         8'h09, 8'h0A:               return "R4";
         8'h05, 8'h06, 8'h07, 8'h08: return "R5";
         8'h14, 8'h15:               return "R6";
         8'h0B:                      return "R8";
         8'h0C:                      return "R9";
         default:                    return "R13";
      endcase
   endfunction

   // drive one request and wait for done; edges counts from the accepting edge
   task automatic run_op(input logic [7:0] op, input logic [W-1:0] v,
                         output int edges, output bit busy_seen, output bit dz_seen);
      @(negedge clk);
      opcode  = op;
      operand = v;
      start   = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start     = 1'b0;
      edges     = 1;
      busy_seen = busy;
      while (!done && edges < 300) begin
         @(posedge clk);
         @(negedge clk);
         edges++;
         if (busy) busy_seen = 1'b1;
      end
      dz_seen = div_by_zero;
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int  edges;
      bit  bs;
      bit  dz;

      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", "ac in reset", ac_out, '0);
      check("R1", "busy in reset", busy, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "ac", ac_out, '0);
      check("R1", "mq", mq_out, '0);
      check("R1", "busy", busy, 1'b0);
      check("R1", "done", done, 1'b0);
      check("R1", "div_by_zero", div_by_zero, 1'b0);

      // vector table
      for (int i = 0; i < NV; i++) begin
         run_op(TBL[i].op, TBL[i].opnd, edges, bs, dz);
         check(tag_of(TBL[i].op), $sformatf("ac row %0d", i), ac_out, TBL[i].ac);
         check(tag_of(TBL[i].op), $sformatf("mq row %0d", i), mq_out, TBL[i].mq);
         check("R2", $sformatf("sign row %0d", i), ac_neg, TBL[i].ac[W-1]);
         check("R11", $sformatf("no error row %0d", i), dz, 1'b0);
         if (TBL[i].op == 8'h0B || TBL[i].op == 8'h0C) begin
            check("R10", $sformatf("latency row %0d", i), edges, W + 2);
         end else begin
            check("R7", $sformatf("latency row %0d", i), edges, 1);
            check("R7", $sformatf("busy row %0d", i), bs, 1'b0);
         end
      end

      // R11: divide by zero keeps AC and MQ
      run_op(8'h01, 40'sd55, edges, bs, dz);
      run_op(8'h09, 40'sd66, edges, bs, dz);
      run_op(8'h0C, 40'sd0, edges, bs, dz);
      check("R11", "flag", dz, 1'b1);
      check("R11", "latency", edges, 1);
      check("R11", "ac kept", ac_out, 40'sd55);
      check("R11", "mq kept", mq_out, 40'sd66);
      @(negedge clk);
      check("R11", "flag cleared", div_by_zero, 1'b0);

      // R12: start during a multiply is ignored
      run_op(8'h01, 40'sd5, edges, bs, dz);
      run_op(8'h09, 40'sd3, edges, bs, dz);
      @(negedge clk);
      opcode  = 8'h0B;
      operand = 40'sd4;
      start   = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      opcode  = 8'h01;
      operand = 40'sd999;
      start   = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R14", "ac held while busy", ac_out, 40'sd5);
      check("R12", "still busy", busy, 1'b1);
      edges = 0;
      while (!done && edges < 300) begin
         @(negedge clk);
         edges++;
      end
      check("R12", "ac product high", ac_out, 40'sd0);
      check("R12", "mq product low", mq_out, 40'sd12);
      repeat (4) begin
         @(negedge clk);
         check("R12", "no extra done", done, 1'b0);
         check("R12", "ac untouched", ac_out, 40'sd0);
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule